// File: doc/BRIEF.md
# Predicated Gather Prefetch Address Generator

This block turns one vector gather-prefetch operation into a stream of prefetch hint requests. A command gives a 64-bit scalar base, a vector of index lanes, a byte-granular predicate and a 4-bit prefetch operation code. The block works through the vector's elements from the lowest to the highest. For each element whose predicate bit is set, it emits one request. The request address is the base plus the element's index multiplied by eight. The request also carries a read/write hint, a target cache level and a non-temporal flag, all decoded from the operation code.

Three indexing modes select how the lanes are read. In the first, the vector is split into 32-bit lanes. In the second, it is split into 64-bit lanes and only the low 32 bits of each lane are used. In the third, each full 64-bit lane is an unsigned index. In the two 32-bit index modes, a select bit chooses zero or sign extension of the index to 64 bits. Requests leave through a valid/ready handshake, at most one per cycle. A single-cycle done pulse closes every command, including a command that produces no requests.

The vector width `VLEN` is a parameter. It must be a power of two of at least 128 bits.

Top module: `gather_prefetch_gen`

## Requirements
- R1: Every request address equals `base + (offset << 3)` modulo 2^64, where offset is the element's index after extension.
- R2: Mode `idx_mode = 2'b00` splits the vector into VLEN/32 elements. Element e uses bits [32e+31:32e] as its index and is active when `pred[4e]` is set.
- R3: Mode `idx_mode = 2'b01` splits the vector into VLEN/64 elements. Element e uses only bits [64e+31:64e] as its index and is active when `pred[8e]` is set. Predicate bits at other positions have no effect.
- R4: In modes 2'b00 and 2'b01, `sign_ext = 0` zero-extends the 32-bit index to 64 bits and `sign_ext = 1` sign-extends it.
- R5: Modes 2'b10 and 2'b11 split the vector into VLEN/64 elements. Each element's full 64-bit lane is an unsigned index and `sign_ext` has no effect. Element e is active when `pred[8e]` is set.
- R6: Requests are made only for active elements, one per active element, in ascending element order.
- R7: The request hint fields come from `prf_op`: `req_write = prf_op[3]` (1 = write), `req_level = prf_op[2:1]` (0 = L1, 1 = L2, 2 = L3) and `req_stream = prf_op[0]` (1 = non-temporal).
- R8: When `prf_op[2:1] = 2'b11`, the command produces no request and still ends with a done pulse.
- R9: A command with no active element produces no request. `done` is then high in the cycle right after the start edge.
- R10: While `req_valid` is high and `req_ready` is low, the request and its address and hint fields hold stable into the next cycle.
- R11: `done` is high for exactly one cycle: the cycle after the edge that accepts the last request. `req_valid` is low during that cycle and `busy` is low in the cycle after it.
- R12: `start` is sampled only while `busy` is low. A start during a walk has no effect on the walk's requests.
- R13: After reset, `busy`, `req_valid` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (sampled when not busy) |
| base | input | 64 | Scalar base address |
| index_vec | input | VLEN | Vector of index lanes |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| idx_mode | input | 2 | Indexing mode (00 narrow, 01 unpacked, 10/11 wide) |
| sign_ext | input | 1 | Sign-extend 32-bit indices when set |
| prf_op | input | 4 | Prefetch operation code |
| busy | output | 1 | A command is being walked |
| req_valid | output | 1 | Prefetch request offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | 64 | Prefetch address |
| req_write | output | 1 | Write hint (0 = read) |
| req_level | output | 2 | Target cache level |
| req_stream | output | 1 | Non-temporal hint |
| done | output | 1 | Command completion pulse |

## Verification
The start edge captures the command, so the first request or the done pulse is visible in the very next cycle. Each later request appears one cycle after its predecessor is accepted, and done appears one cycle after the final accept. The bench drives inputs and samples outputs on falling edges. It accounts for a handshake only at the falling edge after the rising edge that accepts it. At each falling edge it requires `done` to equal "all expected requests accepted", and it compares the address offered there against a model scan of the command. After any falling edge that showed a stall, the next falling edge must show the same request again.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

    localparam int unsigned ADDR_W = 64;
    localparam int unsigned IDX_SCALE = 3;

    typedef enum logic [1:0] {
        IDX_NARROW  = 2'b00,
        IDX_UNPACK  = 2'b01,
        IDX_WIDE    = 2'b10,
        IDX_WIDE_B  = 2'b11
    } idx_mode_e;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WALK = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic       write;
        logic [1:0] level;
        logic       stream;
    } pf_hint_t;

    typedef struct packed {
        idx_mode_e mode;
        logic      sx;
        logic [3:0] op;
    } walk_cfg_t;

    function automatic pf_hint_t decode_hint(input logic [3:0] op);
        pf_hint_t h;
        h.write  = op[3];
        h.level  = op[2:1];
        h.stream = op[0];
        return h;
    endfunction

    function automatic logic is_unnamed_op(input logic [3:0] op);
        return op[2:1] == 2'b11;
    endfunction

    function automatic logic uses_narrow_index(input idx_mode_e m);
        return (m == IDX_NARROW) || (m == IDX_UNPACK);
    endfunction

    function automatic logic [ADDR_W-1:0] extend_index(input logic [63:0] lane,
                                                      input idx_mode_e  m,
                                                      input logic       sx);
        logic [ADDR_W-1:0] r;
        if (uses_narrow_index(m)) begin
            r = sx ? {{32{lane[31]}}, lane[31:0]} : {32'b0, lane[31:0]};
        end else begin
            r = lane;
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] scaled_addr(input logic [ADDR_W-1:0] b,
                                                     input logic [ADDR_W-1:0] off);
        return b + (off << IDX_SCALE);
    endfunction

endpackage

// File: rtl/gpf_active_mask.sv
module gpf_active_mask
    import gpf_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN/8-1:0]  pred,
    input  idx_mode_e          mode,
    output logic [VLEN/32-1:0] active
);
    localparam int unsigned MAX_ELEMS  = VLEN / 32;
    localparam int unsigned WIDE_ELEMS = VLEN / 64;

    logic [MAX_ELEMS-1:0] narrow_act;
    logic [MAX_ELEMS-1:0] wide_act;

    for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_elem
        assign narrow_act[e] = pred[e*4];
        if (e < WIDE_ELEMS) begin : g_wide
            assign wide_act[e] = pred[e*8];
        end else begin : g_pad
            assign wide_act[e] = 1'b0;
        end
    end

    always_comb begin
        active = (mode == IDX_NARROW) ? narrow_act : wide_act;
    end

endmodule

// File: rtl/gpf_first_pick.sv
module gpf_first_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int unsigned IDX_W = $clog2(N);

    always_comb begin
        grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
        any   = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = i[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gpf_lane_mux.sv
module gpf_lane_mux
    import gpf_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic [VLEN-1:0]              vec,
    input  idx_mode_e                    mode,
    input  logic                         sx,
    input  logic [$clog2(VLEN/32)-1:0]   sel,
    output logic [ADDR_W-1:0]            offset
);
    localparam int unsigned MAX_ELEMS  = VLEN / 32;
    localparam int unsigned WIDE_ELEMS = VLEN / 64;
    localparam int unsigned WIDE_IDX_W = $clog2(WIDE_ELEMS);

    logic [31:0] narrow_lane [MAX_ELEMS];
    logic [63:0] wide_lane   [WIDE_ELEMS];
    logic [63:0] raw;

    for (genvar e = 0; e < MAX_ELEMS; e++) begin : g_narrow
        assign narrow_lane[e] = vec[e*32 +: 32];
    end
    for (genvar e = 0; e < WIDE_ELEMS; e++) begin : g_wide
        assign wide_lane[e] = vec[e*64 +: 64];
    end

    always_comb begin
        if (mode == IDX_NARROW) begin
            raw = {32'b0, narrow_lane[sel]};
        end else begin
            raw = wide_lane[sel[WIDE_IDX_W-1:0]];
        end
        offset = extend_index(raw, mode, sx);
    end

endmodule

// File: rtl/gather_prefetch_gen.sv
module gather_prefetch_gen
    import gpf_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [63:0]       base,
    input  logic [VLEN-1:0]   index_vec,
    input  logic [VLEN/8-1:0] pred,
    input  logic [1:0]        idx_mode,
    input  logic              sign_ext,
    input  logic [3:0]        prf_op,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [63:0]       req_addr,
    output logic              req_write,
    output logic [1:0]        req_level,
    output logic              req_stream,
    output logic              done
);
    localparam int unsigned MAX_ELEMS = VLEN / 32;
    localparam int unsigned SEL_W     = $clog2(MAX_ELEMS);

    walk_state_e          state_q;
    walk_cfg_t            cfg_q;
    logic [ADDR_W-1:0]    base_q;
    logic [VLEN-1:0]      vec_q;
    logic [MAX_ELEMS-1:0] pending_q;

    idx_mode_e            in_mode;
    logic [MAX_ELEMS-1:0] in_active;
    logic [MAX_ELEMS-1:0] grant;
    logic [SEL_W-1:0]     sel;
    logic                 have_pending;
    logic [ADDR_W-1:0]    offset;
    pf_hint_t             hint;
    logic                 accept_cmd;
    logic                 fire;

    assign in_mode = idx_mode_e'(idx_mode);

    gpf_active_mask #(.VLEN(VLEN)) i_mask (
        .pred   (pred),
        .mode   (in_mode),
        .active (in_active)
    );

    gpf_first_pick #(.N(MAX_ELEMS)) i_pick (
        .req   (pending_q),
        .grant (grant),
        .idx   (sel),
        .any   (have_pending)
    );

    gpf_lane_mux #(.VLEN(VLEN)) i_lane (
        .vec    (vec_q),
        .mode   (cfg_q.mode),
        .sx     (cfg_q.sx),
        .sel    (sel),
        .offset (offset)
    );

    assign accept_cmd = (state_q == WS_IDLE) && start;
    assign fire       = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WS_IDLE;
            cfg_q     <= '{mode: IDX_NARROW, sx: 1'b0, op: 4'b0};
            base_q    <= '0;
            vec_q     <= '0;
            pending_q <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (accept_cmd) begin
                        state_q       <= WS_WALK;
                        cfg_q.mode    <= in_mode;
                        cfg_q.sx      <= sign_ext;
                        cfg_q.op      <= prf_op;
                        vec_q         <= index_vec;
                        if (is_unnamed_op(prf_op)) begin
                            pending_q <= '0;
                        end else begin
                            pending_q <= in_active;
                        end
                        if ((|in_active) && !is_unnamed_op(prf_op)) begin
                            base_q    <= base;
                        end
                    end
                end
                WS_WALK: begin
                    if (!have_pending) begin
                        state_q <= WS_IDLE;
                    end else if (fire) begin
                        pending_q <= pending_q & ~grant;
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        hint       = decode_hint(cfg_q.op);
        busy       = (state_q == WS_WALK);
        req_valid  = busy && have_pending;
        done       = busy && !have_pending;
        req_addr   = scaled_addr(base_q, offset);
        req_write  = hint.write;
        req_level  = hint.level;
        req_stream = hint.stream;
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
            $stable(req_write) && $stable(req_level) && $stable(req_stream)));

    // R11
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R8
    no_unnamed_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_level != 2'b11));

    // R6
    pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (req_valid == (grant != '0)));

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(base_q) && $stable(vec_q)));

endmodule

// File: tb/test_gather_prefetch_gen.sv
module test_gather_prefetch_gen;

    localparam int VL = 256;

    typedef struct packed {
        logic [1:0]    mode;
        logic          sx;
        logic [3:0]    op;
        logic [63:0]   base;
        logic [VL-1:0] vec;
        logic [31:0]   pred;
        logic [7:0]    rdy;
    } case_t;

    localparam logic [VL-1:0] VEC_A = {32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0010, 32'hDEAD_BEEF,
                                       32'h1234_5678, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0001};
    localparam logic [VL-1:0] VEC_B = {64'hABCD_0000_FFFF_FFF0, 64'h5555_AAAA_0000_0004,
                                       64'h1111_2222_8000_0001, 64'hFFFF_FFFF_0000_0002};

    localparam int NCASE = 10;
    localparam case_t CASES [NCASE] = '{
        '{2'b00, 1'b0, 4'b0000, 64'h0000_0000_0000_1000, VEC_A, 32'hFFFF_FFFF, 8'hFF},
        '{2'b00, 1'b1, 4'b1001, 64'h0000_0000_0010_0000, VEC_A, 32'h1111_1111, 8'hA5},
        '{2'b01, 1'b1, 4'b0101, 64'h0000_0000_0000_4000, VEC_B, 32'h0101_0101, 8'h6D},
        '{2'b01, 1'b0, 4'b1011, 64'h0000_0000_0000_4000, VEC_B, 32'h0101_0101, 8'hFF},
        '{2'b10, 1'b1, 4'b1010, 64'hFFFF_FFFF_FFFF_FFF0, VEC_B, 32'h0101_0101, 8'h33},
        '{2'b00, 1'b1, 4'b0011, 64'h0000_0000_0000_0800, VEC_A, 32'h0010_0015, 8'hFF},
        '{2'b00, 1'b0, 4'b0000, 64'h0000_0000_0000_0800, VEC_A, 32'h0000_0000, 8'hFF},
        '{2'b00, 1'b0, 4'b1110, 64'h0000_0000_0000_0800, VEC_A, 32'hFFFF_FFFF, 8'hFF},
        '{2'b01, 1'b0, 4'b0000, 64'h0000_0000_0000_0800, VEC_B, 32'h1010_1010, 8'hFF},
        '{2'b11, 1'b0, 4'b0100, 64'h0000_0000_0000_0000, VEC_B, 32'h0100_0001, 8'hFF}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [63:0]       base;
    logic [VL-1:0]     index_vec;
    logic [VL/8-1:0]   pred;
    logic [1:0]        idx_mode;
    logic              sign_ext;
    logic [3:0]        prf_op;
    logic              busy;
    logic              req_valid;
    logic              req_ready;
    logic [63:0]       req_addr;
    logic              req_write;
    logic [1:0]        req_level;
    logic              req_stream;
    logic              done;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_addr [8];
    int          exp_n;

    always #4 clk = ~clk;

    gather_prefetch_gen #(.VLEN(VL)) i_gather_prefetch_gen (
        .clk(clk), .rst(rst), .start(start), .base(base), .index_vec(index_vec),
        .pred(pred), .idx_mode(idx_mode), .sign_ext(sign_ext), .prf_op(prf_op),
        .busy(busy), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_level(req_level), .req_stream(req_stream), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of R1-R6 and R8: list of expected addresses in ascending element order.
    task automatic build_expect(input case_t c);
        int n_el;
        int step;
        logic [63:0] lane;
        logic [63:0] off;
        exp_n = 0;
        n_el  = (c.mode == 2'b00) ? 8 : 4;
        step  = (c.mode == 2'b00) ? 4 : 8;
        if (c.op[2:1] == 2'b11) return;
        for (int e = 0; e < n_el; e++) begin
            if (c.pred[e*step]) begin
                lane = (c.mode == 2'b00) ? {32'b0, c.vec[e*32 +: 32]} : c.vec[e*64 +: 64];
                if (c.mode[1]) off = lane;
                else if (c.sx) off = {{32{lane[31]}}, lane[31:0]};
                else off = {32'b0, lane[31:0]};
                exp_addr[exp_n] = c.base + off * 64'd8;
                exp_n++;
            end
        end
    endtask

    task automatic run_case(input case_t c, input bit poke);
        int  got = 0;
        bit  hs_pend = 0;
        bit  stall_pend = 0;
        bit  finished = 0;
        logic [63:0] prev_addr = '0;
        build_expect(c);
        @(negedge clk);
        start = 1'b1; base = c.base; index_vec = c.vec; pred = c.pred;
        idx_mode = c.mode; sign_ext = c.sx; prf_op = c.op; req_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 64; cyc++) begin
            if (hs_pend) got++;
            if (stall_pend)
                check(req_valid && req_addr == prev_addr, "R10 stall hold", req_addr, prev_addr);
            // R9 R11: done exactly when all expected requests are accepted
            check(done == (got == exp_n), "R11 R9 done timing", 64'(done), 64'(got == exp_n));
            if (done) begin
                check(!req_valid, "R11 valid low with done", 64'(req_valid), 64'd0);
                finished = 1;
                break;
            end
            if (req_valid) begin
                if (got < exp_n) begin
                    check(req_addr == exp_addr[got], "R1 R6 address", req_addr, exp_addr[got]);
                    check({req_write, req_level, req_stream} == c.op, "R7 hint",
                          64'({req_write, req_level, req_stream}), 64'(c.op));
                end else begin
                    check(1'b0, "R6 R8 extra request", req_addr, 64'd0);
                end
            end
            req_ready  = c.rdy[cyc % 8];
            hs_pend    = req_valid && req_ready;
            stall_pend = req_valid && !req_ready;
            prev_addr  = req_addr;
            // R12: a start during the walk with another base must be ignored
            start = poke && (cyc == 1);
            if (poke) base = ~c.base;
            @(negedge clk);
        end
        start = 1'b0;
        check(finished == 1'b1, "R11 walk completion", 64'(finished), 64'd1);
        @(negedge clk);
        check(!busy && !done, "R11 idle after done", {busy, done}, 64'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; base = '0; index_vec = '0; pred = '0;
        idx_mode = 2'b00; sign_ext = 1'b0; prf_op = 4'b0; req_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(!busy && !req_valid && !done, "R13 reset", {busy, req_valid, done}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !req_valid && !done, "R13 idle after reset", {busy, req_valid, done}, 64'd0);

        // Table: R2 narrow, R4 extension, R3 unpacked, R5 wide with wrap, R8 unnamed, R9 empty
        for (int k = 0; k < NCASE; k++) begin
            run_case(CASES[k], 1'b0);
        end

        // R12: start held during a slow walk
        run_case(CASES[1], 1'b1);

        // R5: sign_ext has no effect in wide mode
        begin
            case_t c;
            c = CASES[4];
            c.sx = 1'b0;
            run_case(c, 1'b0);
        end

        // R13: reset in the middle of a walk returns to idle
        @(negedge clk);
        start = 1'b1; base = 64'h100; index_vec = VEC_A; pred = '1;
        idx_mode = 2'b00; sign_ext = 1'b0; prf_op = 4'b0; req_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(req_valid == 1'b1, "R6 first request offered", 64'(req_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !req_valid && !done, "R13 mid-walk reset", {busy, req_valid, done}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule